// File: doc/BRIEF.md
# Dual-Clock Transaction-Tagged FIFO

This block moves bus transactions from one clock domain to another. Every stored entry is made of three fields that travel together: a 32-bit address or data word, a 4-bit byte-enable or command field, and a 4-bit control tag. The tag says whether the entry opens a transaction, because it carries the address, and whether it closes one. The producer pushes on its own clock. The consumer pops on an unrelated clock and sees the head entry on its outputs before it pops.

The block has the usual word-level status: full and almost-full on the write side, empty and almost-empty on the read side. It also raises a transaction-ready flag on the read side when at least one complete transaction, up to and including its closing entry, is held in storage. A consumer waits for not-empty and transaction-ready together, then drains the transaction. A one-cycle flush pulse on the read side throws away everything the read side can see. Depth is a parameter, so one instance can serve posted writes and a second instance can serve read completions in the other direction.

Top module: `txn_xfifo`

## Requirements
- R1: While rst_n is low at a clock edge, that domain clears its state. After reset, rd_empty=1, rd_almost_empty=0, rd_txn_ready=0, wr_full=0 and wr_almost_full=0.
- R2: The data, byte-enable and tag fields of each entry come out together on rd_data, rd_be and rd_tag, in the order they were pushed. The head entry is visible before it is popped.
- R3: Tag bit 0 set (value 1) marks the closing entry of a transaction. Tag bit 1 set (value 2) marks the address entry. Only bit 0 affects transaction detection, and all four tag bits are passed through unchanged.
- R4: rd_txn_ready is high only while at least one closing-tagged entry is stored and not yet popped. It stays high after one transaction is drained if another complete one remains. An open transaction that has no closing entry yet leaves it low.
- R5: rd_almost_empty is high exactly when one entry is visible to the reader. rd_empty is high when none is visible, and the two are never high together.
- R6: wr_almost_full is high exactly when one free slot remains. wr_full is high when all 2**ADDR_W slots are in use, and the two are never high together.
- R7: A push while wr_full is high is ignored. The write pointer is unchanged and the word is never delivered.
- R8: A pop while rd_empty is high is ignored. The read pointer is unchanged, so the next pushed entry is the one delivered.
- R9: A flush pulse makes the next read-side cycle report rd_empty=1 and rd_txn_ready=0. The entries it covered are never delivered, and entries pushed afterwards are delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_push | input | 1 | Push one entry on the next wclk edge |
| wr_data | input | 32 | Address or data word to store |
| wr_be | input | 4 | Byte-enable or command field to store |
| wr_tag | input | 4 | Control tag (bit 0 closing, bit 1 address) |
| wr_full | output | 1 | All slots in use |
| wr_almost_full | output | 1 | Exactly one free slot |
| rd_pop | input | 1 | Pop the head entry on the next rclk edge |
| rd_flush | input | 1 | Discard all entries visible to the reader |
| rd_data | output | 32 | Head entry word |
| rd_be | output | 4 | Head entry byte-enable or command |
| rd_tag | output | 4 | Head entry control tag |
| rd_empty | output | 1 | No entry visible |
| rd_almost_empty | output | 1 | Exactly one entry visible |
| rd_txn_ready | output | 1 | At least one complete transaction stored |

## Verification
The main function is tried with four patterns:
- A three-entry transaction (address, middle, closing) built up gradually. This separates "entries present" from "transaction complete".
- A single entry that is both address and closing. This shows that the closing tag on a first entry counts as a full transaction.
- Two back-to-back transactions. These show that transaction-ready follows a count and not a single flag.
- A fill to full with no closing tags. This exercises the word flags apart from the transaction flag, and an overflow push on top of it shows which word is dropped.

After the FIFO is drained, a pop is issued on empty and a flush is issued with data stored. Each is followed by a fresh push, which shows whether the read pointer moved when it should not have, or failed to move.

// File: rtl/txn_xfifo_pkg.sv
// Shared widths, tag bit positions and the entry type for the
// transaction-tagged dual-clock FIFO.
package txn_xfifo_pkg;
    localparam int DATA_W       = 32;
    localparam int BE_W         = 4;
    localparam int TAG_W        = 4;
    localparam int TAG_LAST_BIT = 0;
    localparam int TAG_ADDR_BIT = 1;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [BE_W-1:0]   be;
        logic [TAG_W-1:0]  tag;
    } entry_t;
endpackage

// File: rtl/txn_gray_sync.sv
// Two-flop synchronizer for a Gray-coded counter.
// It also decodes the result back to binary. bin_q is the settled value.
// bin_nxt is the value that becomes bin_q on the next edge.
// Assumes the source changes by at most one Gray step per source clock.
module txn_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_q,
    output logic [W-1:0] bin_nxt
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Purpose: two-stage capture of the foreign-domain Gray value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Purpose: Gray to binary decode of both stages.
    always_comb begin
        bin_q[W-1]   = stage2[W-1];
        bin_nxt[W-1] = stage1[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_q[i]   = bin_q[i+1] ^ stage2[i];
            bin_nxt[i] = bin_nxt[i+1] ^ stage1[i];
        end
    end
endmodule

// File: rtl/txn_fifo_store.sv
// Entry storage. Writes happen on the write clock. The read is combinational,
// so the head entry is shown without a pop.
// Assumes the caller never writes a slot that is still visible to the reader.
module txn_fifo_store #(
    parameter int ADDR_W = 3
) (
    input  logic                  wclk,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  txn_xfifo_pkg::entry_t wentry,
    input  logic [ADDR_W-1:0]     raddr,
    output txn_xfifo_pkg::entry_t rentry
);
    localparam int DEPTH = 1 << ADDR_W;

    txn_xfifo_pkg::entry_t mem [DEPTH];

    // Purpose: store one entry per accepted push.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/txn_fifo_wr.sv
// Write-domain control. It keeps the write pointer and a count of pushed
// closing entries, both also in Gray code, and derives full and almost-full
// from the synchronized read pointer.
// Assumes rd_ptr_sync lags the true read pointer, so these flags are pessimistic.
module txn_fifo_wr #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_last,
    input  logic [ADDR_W:0]   rd_ptr_sync,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   wr_gray,
    output logic [ADDR_W:0]   last_gray,
    output logic              we,
    output logic              full,
    output logic              almost_full
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P  = PTR_W'(1 << ADDR_W);
    localparam logic [PTR_W-1:0] DEPTH_M1 = PTR_W'((1 << ADDR_W) - 1);

    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] last_cnt;
    logic [PTR_W-1:0] wr_ptr_inc;
    logic [PTR_W-1:0] last_inc;

    assign used        = wr_ptr - rd_ptr_sync;
    assign full        = (used == DEPTH_P);
    assign almost_full = (used == DEPTH_M1);
    assign we          = push && !full;
    assign wr_ptr_inc  = wr_ptr + 1'b1;
    assign last_inc    = last_cnt + 1'b1;

    // Purpose: advance the pointer and the closing-entry count on a push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            wr_gray   <= '0;
            last_cnt  <= '0;
            last_gray <= '0;
        end else if (we) begin
            wr_ptr  <= wr_ptr_inc;
            wr_gray <= wr_ptr_inc ^ (wr_ptr_inc >> 1);
            if (push_last) begin
                last_cnt  <= last_inc;
                last_gray <= last_inc ^ (last_inc >> 1);
            end
        end
    end
endmodule

// File: rtl/txn_fifo_rd.sv
// Read-domain control. It keeps the read pointer and a count of popped
// closing entries, and derives empty, almost-empty and transaction-ready.
// A flush jumps both counters to the write-side values that arrive on the
// same edge, so the next cycle is empty.
// Assumes the synchronized inputs lag the write side, so these flags are pessimistic.
module txn_fifo_rd #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              flush,
    input  logic              head_last,
    input  logic [ADDR_W:0]   wr_ptr_q,
    input  logic [ADDR_W:0]   wr_ptr_nxt,
    input  logic [ADDR_W:0]   wr_last_q,
    input  logic [ADDR_W:0]   wr_last_nxt,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              empty,
    output logic              almost_empty,
    output logic              txn_ready
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] avail;
    logic [PTR_W-1:0] last_cnt;
    logic [PTR_W-1:0] rd_ptr_inc;
    logic             take;

    assign avail        = wr_ptr_q - rd_ptr;
    assign empty        = (avail == '0);
    assign almost_empty = (avail == PTR_W'(1));
    assign txn_ready    = (last_cnt != wr_last_q);
    assign take         = pop && !empty && !flush;
    assign rd_ptr_inc   = rd_ptr + 1'b1;

    // Purpose: advance on a pop, or skip to the write side on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rd_gray  <= '0;
            last_cnt <= '0;
        end else if (flush) begin
            rd_ptr   <= wr_ptr_nxt;
            rd_gray  <= wr_ptr_nxt ^ (wr_ptr_nxt >> 1);
            last_cnt <= wr_last_nxt;
        end else if (take) begin
            rd_ptr  <= rd_ptr_inc;
            rd_gray <= rd_ptr_inc ^ (rd_ptr_inc >> 1);
            if (head_last) begin
                last_cnt <= last_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txn_xfifo.sv
// Top level of the dual-clock transaction-tagged FIFO.
// Pointers and the closing-entry count cross the clock domains in Gray code
// through two-flop synchronizers. Depth is 2**ADDR_W.
// Assumes rst_n is held low for several cycles of both clocks.
module txn_xfifo #(
    parameter int ADDR_W = 3
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst_n,
    input  logic        wr_push,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be,
    input  logic [3:0]  wr_tag,
    output logic        wr_full,
    output logic        wr_almost_full,
    input  logic        rd_pop,
    input  logic        rd_flush,
    output logic [31:0] rd_data,
    output logic [3:0]  rd_be,
    output logic [3:0]  rd_tag,
    output logic        rd_empty,
    output logic        rd_almost_empty,
    output logic        rd_txn_ready
);
    import txn_xfifo_pkg::*;

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_ptr, wr_gray, wr_last_gray;
    logic [PTR_W-1:0] rd_ptr, rd_gray;
    logic [PTR_W-1:0] rd_ptr_sync, rd_ptr_sync_nxt;
    logic [PTR_W-1:0] wr_ptr_sync, wr_ptr_sync_nxt;
    logic [PTR_W-1:0] wr_last_sync, wr_last_sync_nxt;
    logic             we;
    entry_t           wentry, rentry;

    assign wentry = '{word: wr_data, be: wr_be, tag: wr_tag};

    txn_fifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wclk), .rst_n(rst_n), .push(wr_push),
        .push_last(wr_tag[TAG_LAST_BIT]), .rd_ptr_sync(rd_ptr_sync),
        .wr_ptr(wr_ptr), .wr_gray(wr_gray), .last_gray(wr_last_gray),
        .we(we), .full(wr_full), .almost_full(wr_almost_full)
    );

    txn_fifo_store #(.ADDR_W(ADDR_W)) u_store (
        .wclk(wclk), .we(we), .waddr(wr_ptr[ADDR_W-1:0]), .wentry(wentry),
        .raddr(rd_ptr[ADDR_W-1:0]), .rentry(rentry)
    );

    txn_gray_sync #(.W(PTR_W)) u_sync_rptr (
        .clk(wclk), .rst_n(rst_n), .gray_in(rd_gray),
        .bin_q(rd_ptr_sync), .bin_nxt(rd_ptr_sync_nxt)
    );

    txn_gray_sync #(.W(PTR_W)) u_sync_wptr (
        .clk(rclk), .rst_n(rst_n), .gray_in(wr_gray),
        .bin_q(wr_ptr_sync), .bin_nxt(wr_ptr_sync_nxt)
    );

    txn_gray_sync #(.W(PTR_W)) u_sync_wlast (
        .clk(rclk), .rst_n(rst_n), .gray_in(wr_last_gray),
        .bin_q(wr_last_sync), .bin_nxt(wr_last_sync_nxt)
    );

    txn_fifo_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rclk), .rst_n(rst_n), .pop(rd_pop), .flush(rd_flush),
        .head_last(rentry.tag[TAG_LAST_BIT]),
        .wr_ptr_q(wr_ptr_sync), .wr_ptr_nxt(wr_ptr_sync_nxt),
        .wr_last_q(wr_last_sync), .wr_last_nxt(wr_last_sync_nxt),
        .rd_ptr(rd_ptr), .rd_gray(rd_gray), .empty(rd_empty),
        .almost_empty(rd_almost_empty), .txn_ready(rd_txn_ready)
    );

    assign rd_data = rentry.word;
    assign rd_be   = rentry.be;
    assign rd_tag  = rentry.tag;

    // The next-stage value of the read pointer is not needed on the write side.
    logic unused_ok;
    assign unused_ok = ^rd_ptr_sync_nxt;
endmodule

// File: rtl/txn_xfifo_chk.sv
// Assertion checker for txn_xfifo, attached by bind.
// Assumes the top-level pointer signals wr_ptr and rd_ptr.
module txn_xfifo_chk #(
    parameter int PTR_W = 4
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wr_push,
    input logic             wr_full,
    input logic             wr_almost_full,
    input logic             rd_pop,
    input logic             rd_flush,
    input logic             rd_empty,
    input logic             rd_almost_empty,
    input logic             rd_txn_ready,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    // R7
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_push && wr_full) |=> $stable(wr_ptr));

    // R8
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_pop && rd_empty && !rd_flush) |=> $stable(rd_ptr));

    // R6
    full_excl_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_full |-> !wr_almost_full);

    // R5
    empty_excl_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_empty |-> !rd_almost_empty);

    // R4
    ready_needs_data_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_txn_ready |-> !rd_empty);

    // R9
    flush_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_flush |=> (rd_empty && !rd_txn_ready));
endmodule

bind txn_xfifo txn_xfifo_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_push(wr_push), .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_pop(rd_pop), .rd_flush(rd_flush), .rd_empty(rd_empty),
    .rd_almost_empty(rd_almost_empty), .rd_txn_ready(rd_txn_ready),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/txn_xfifo_tb.sv
// Directed bench for txn_xfifo: one task per scenario, each checking its results.
module txn_xfifo_tb;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [3:0] T_ADDR = 4'h2;
    localparam logic [3:0] T_LAST = 4'h1;
    localparam logic [3:0] T_MID  = 4'h4;

    logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic        wr_push = 1'b0, rd_pop = 1'b0, rd_flush = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0, wr_tag = '0;
    logic        wr_full, wr_almost_full;
    logic [31:0] rd_data;
    logic [3:0]  rd_be, rd_tag;
    logic        rd_empty, rd_almost_empty, rd_txn_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 wclk = ~wclk;
    always #17 rclk = ~rclk;

    txn_xfifo #(.ADDR_W(ADDR_W)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_push(wr_push), .wr_data(wr_data), .wr_be(wr_be), .wr_tag(wr_tag),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .rd_pop(rd_pop), .rd_flush(rd_flush),
        .rd_data(rd_data), .rd_be(rd_be), .rd_tag(rd_tag),
        .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty),
        .rd_txn_ready(rd_txn_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d, input logic [3:0] b, input logic [3:0] t);
        @(negedge wclk);
        wr_push = 1'b1; wr_data = d; wr_be = b; wr_tag = t;
        @(posedge wclk);
        #1 wr_push = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] d,
                           input logic [3:0] b, input logic [3:0] t);
        @(negedge rclk);
        chk(req, "rd_data", rd_data, d);
        chk(req, "rd_be", {28'd0, rd_be}, {28'd0, b});
        chk(req, "rd_tag", {28'd0, rd_tag}, {28'd0, t});
        rd_pop = 1'b1;
        @(posedge rclk);
        #1 rd_pop = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
        settle();
        @(negedge rclk);
        chk("R1", "rd_empty", {31'd0, rd_empty}, 32'd1);
        chk("R1", "rd_almost_empty", {31'd0, rd_almost_empty}, 32'd0);
        chk("R1", "rd_txn_ready", {31'd0, rd_txn_ready}, 32'd0);
        @(negedge wclk);
        chk("R1", "wr_full", {31'd0, wr_full}, 32'd0);
        chk("R1", "wr_almost_full", {31'd0, wr_almost_full}, 32'd0);
    endtask

    task automatic t_three_entry();
        push(32'hA000_0000, 4'hF, T_ADDR);
        push(32'h0000_1234, 4'h3, T_MID);
        settle();
        @(negedge rclk);
        chk("R4", "open txn not empty", {31'd0, rd_empty}, 32'd0);
        chk("R3", "address tag alone not ready", {31'd0, rd_txn_ready}, 32'd0);
        push(32'h0000_5678, 4'hC, T_LAST);
        settle();
        @(negedge rclk);
        chk("R4", "closed txn ready", {31'd0, rd_txn_ready}, 32'd1);
        pop_chk("R2", 32'hA000_0000, 4'hF, T_ADDR);
        pop_chk("R2", 32'h0000_1234, 4'h3, T_MID);
        pop_chk("R3", 32'h0000_5678, 4'hC, T_LAST);
        @(negedge rclk);
        chk("R5", "drained empty", {31'd0, rd_empty}, 32'd1);
        chk("R4", "drained not ready", {31'd0, rd_txn_ready}, 32'd0);
    endtask

    task automatic t_single();
        push(32'h0000_0011, 4'h1, T_ADDR | T_LAST);
        settle();
        @(negedge rclk);
        chk("R4", "single entry ready", {31'd0, rd_txn_ready}, 32'd1);
        chk("R5", "one entry almost empty", {31'd0, rd_almost_empty}, 32'd1);
        chk("R5", "one entry not empty", {31'd0, rd_empty}, 32'd0);
        pop_chk("R2", 32'h0000_0011, 4'h1, T_ADDR | T_LAST);
        @(negedge rclk);
        chk("R5", "after single empty", {31'd0, rd_empty}, 32'd1);
    endtask

    task automatic t_two_txn();
        push(32'h0000_0101, 4'h2, T_ADDR | T_LAST);
        push(32'h0000_0201, 4'h3, T_ADDR);
        push(32'h0000_0202, 4'h4, T_LAST);
        settle();
        pop_chk("R2", 32'h0000_0101, 4'h2, T_ADDR | T_LAST);
        @(negedge rclk);
        chk("R4", "second txn keeps ready", {31'd0, rd_txn_ready}, 32'd1);
        pop_chk("R2", 32'h0000_0201, 4'h3, T_ADDR);
        @(negedge rclk);
        chk("R4", "ready until closing popped", {31'd0, rd_txn_ready}, 32'd1);
        pop_chk("R2", 32'h0000_0202, 4'h4, T_LAST);
        @(negedge rclk);
        chk("R4", "both drained not ready", {31'd0, rd_txn_ready}, 32'd0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH - 1; i++) push(32'h100 + i, 4'(i), 4'h0);
        settle();
        @(negedge wclk);
        chk("R6", "one slot free almost_full", {31'd0, wr_almost_full}, 32'd1);
        chk("R6", "one slot free not full", {31'd0, wr_full}, 32'd0);
        push(32'h100 + DEPTH - 1, 4'(DEPTH - 1), 4'h0);
        @(negedge wclk);
        chk("R6", "full", {31'd0, wr_full}, 32'd1);
        chk("R6", "full not almost", {31'd0, wr_almost_full}, 32'd0);
        push(32'hDEAD_BEEF, 4'hF, T_LAST);
        settle();
        @(negedge wclk);
        chk("R7", "still full after overflow", {31'd0, wr_full}, 32'd1);
        @(negedge rclk);
        chk("R7", "dropped closing entry not counted", {31'd0, rd_txn_ready}, 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) begin
                @(negedge rclk);
                chk("R5", "last entry almost empty", {31'd0, rd_almost_empty}, 32'd1);
            end
            pop_chk("R7", 32'h100 + i, 4'(i), 4'h0);
        end
        @(negedge rclk);
        chk("R5", "fill drained empty", {31'd0, rd_empty}, 32'd1);
        settle();
        @(negedge wclk);
        chk("R6", "drained not full", {31'd0, wr_full}, 32'd0);
    endtask

    task automatic t_pop_empty();
        @(negedge rclk);
        rd_pop = 1'b1;
        @(posedge rclk);
        #1 rd_pop = 1'b0;
        push(32'h0000_0055, 4'h5, T_LAST);
        settle();
        @(negedge rclk);
        chk("R8", "one entry after empty pop", {31'd0, rd_almost_empty}, 32'd1);
        pop_chk("R8", 32'h0000_0055, 4'h5, T_LAST);
    endtask

    task automatic t_flush();
        push(32'h0000_0A01, 4'h1, T_ADDR);
        push(32'h0000_0A02, 4'h2, T_LAST);
        push(32'h0000_0B01, 4'h3, T_ADDR | T_LAST);
        settle();
        @(negedge rclk);
        chk("R9", "ready before flush", {31'd0, rd_txn_ready}, 32'd1);
        rd_flush = 1'b1;
        @(posedge rclk);
        #1 rd_flush = 1'b0;
        @(negedge rclk);
        chk("R9", "empty after flush", {31'd0, rd_empty}, 32'd1);
        chk("R9", "not ready after flush", {31'd0, rd_txn_ready}, 32'd0);
        push(32'h0000_0077, 4'h7, T_LAST);
        settle();
        @(negedge rclk);
        chk("R9", "new entry after flush ready", {31'd0, rd_txn_ready}, 32'd1);
        chk("R9", "only new entry visible", {31'd0, rd_almost_empty}, 32'd1);
        pop_chk("R9", 32'h0000_0077, 4'h7, T_LAST);
    endtask

    initial begin
        t_reset();
        t_three_entry();
        t_single();
        t_two_txn();
        t_fill();
        t_pop_empty();
        t_flush();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule